// File: doc/BRIEF.md
# Read-Only Instruction Cache with Run-Time Replacement Choice

This block sits between a processor's instruction-fetch port and a slow serial flash reader. Fetches whose byte address lies inside a programmable flash window are looked up in a set-associative store. A hit returns the requested 32-bit word on the following cycle. A miss stalls the processor and asks the flash side for one whole line. Once the line has arrived, the block installs it and returns the requested word. Fetches outside the window go to a separate single-word bypass port and leave the cache untouched.

The processor cannot write through this block. Line contents change only when a refill completes. A single input picks how a victim is chosen when every way of a set is occupied: by age (least recently used) or by a per-way saturating use count (least frequently used). Age and count state is kept up to date under both settings, so the choice can be switched between fetches without losing any stored lines. A one-cycle flush input invalidates everything.

Top module: `icache_ro`

## Requirements
- R1: A fetch inside the window that hits raises `cpu_ready` for exactly one cycle, on the cycle after the request is accepted. It returns the stored word and issues no refill.
- R2: A fetch inside the window that misses issues exactly one one-cycle `ref_req`, with `ref_addr` aligned to the line (bits 3:0 zero). It then takes four words on `ref_valid` in ascending word order and returns the word chosen by address bits 3:2. Later fetches to that line hit.
- R3: A fetch with address below `win_base` or at or above `win_limit` is served on the bypass port. It issues no refill and changes no cache state.
- R4: A missing line goes into an invalid way of its set when one exists, using the lowest-numbered invalid way.
- R5: With `policy_lfu` = 0 and the set full, the victim is the way referenced (hit or filled) least recently.
- R6: With `policy_lfu` = 1 and the set full, the victim is the way with the smallest use count, and on a tie the lowest-numbered such way. A hit adds one to the way's count, and a newly filled way starts at 1.
- R7: Use counts saturate at their maximum (7 with the default 3-bit width) and never wrap.
- R8: `policy_lfu` changes only while the block is idle. Changing it invalidates no stored line.
- R9: A one-cycle `flush` clears every valid bit and use count, so the next fetch of any line misses.
- R10: Address bits 7:4 select one of 16 sets, and bits 31:8 form the tag. Up to four lines with the same index and different tags are held at once, and sets do not disturb each other.
- R11: Every word returned for an address inside the window equals the flash word at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines and clear use counts |
| policy_lfu | input | 1 | 0 selects age-based victim, 1 selects use-count victim |
| win_base | input | 32 | First byte address of the cached window |
| win_limit | input | 32 | First byte address after the cached window |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | 32 | Fetch byte address (word aligned) |
| cpu_ready | output | 1 | One-cycle pulse: `cpu_rdata` is valid |
| cpu_rdata | output | 32 | Fetched word |
| ref_req | output | 1 | One-cycle line refill request |
| ref_addr | output | 32 | Line-aligned refill address |
| ref_valid | input | 1 | Refill word strobe, one word per cycle |
| ref_data | input | 32 | Refill word |
| byp_req | output | 1 | Bypass read request, held until `byp_ack` |
| byp_addr | output | 32 | Bypass read address |
| byp_ack | input | 1 | Bypass data valid |
| byp_rdata | input | 32 | Bypass read data |

## Verification
The bench fills all 64 line slots, then sweeps every word of every line. A broken index or tag compare shows up there as refills where hits belong, or as words from the wrong line. Short directed sequences follow, each built so that only one way is a correct victim. They cover LFU ties, where a design that evicts the highest way or the most used way keeps the wrong line. They cover a count driven one past its maximum, which a wrapping counter turns into the smallest count. They cover fill order after a flush and the LRU order after mixed hits. The window edges are probed at exactly the base and the limit, where an off-by-one comparison either refills from flash or sends a cached address to the bypass port.

// File: rtl/icache_pkg.sv
// Shared types for the read-only instruction cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package icache_pkg;

    // Controller sequence: lookup, refill request, refill collect, install,
    // bypass wait, one-cycle response.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_BYP    = 3'd4,
        ST_DONE   = 3'd5
    } ic_state_e;

    // Victim selection choice.
    typedef enum logic {
        POL_LRU = 1'b0,
        POL_LFU = 1'b1
    } ic_policy_e;

endpackage

// File: rtl/icache_tags.sv
// Per-set, per-way tag, valid bit, LRU age rank and LFU use count.
// Ages form a permutation per set: 0 is most recent, WAYS-1 is oldest.
// Assumes WAYS is a power of two of at least 2. Flush and reset restore
// ages to the way number and clear valid bits and counts. One update per cycle.
module icache_tags #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    parameter int CNT_W = 3,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][CNT_W-1:0]       rd_cnt,
    output logic [WAYS-1:0][WAY_W-1:0]       rd_age,
    input  logic                             upd_en,
    input  logic                             upd_fill,
    input  logic [IDX_W-1:0]                 upd_idx,
    input  logic [WAY_W-1:0]                 upd_way,
    input  logic [TAG_W-1:0]                 upd_tag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [SETS-1:0][WAYS-1:0]              valid_q;
    logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]   cnt_q;
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]   age_q;
    logic [TAG_W-1:0]                       tag_q [SETS][WAYS];
    logic [WAY_W-1:0]                       ref_age;

    // Age of the way being touched, used to shift younger ways.
    assign ref_age = age_q[upd_idx][upd_way];

    // Read view of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_valid[w] = valid_q[rd_idx][w];
            rd_tag[w]   = tag_q[rd_idx][w];
            rd_cnt[w]   = cnt_q[rd_idx][w];
            rd_age[w]   = age_q[rd_idx][w];
        end
    end

    // Valid, count and age state with flush taking priority over updates.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    cnt_q[s][w]   <= '0;
                    age_q[s][w]   <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    age_q[upd_idx][w] <= '0;
                end else if (age_q[upd_idx][w] < ref_age) begin
                    age_q[upd_idx][w] <= age_q[upd_idx][w] + 1'b1;
                end
            end
            if (upd_fill) begin
                valid_q[upd_idx][upd_way] <= 1'b1;
                cnt_q[upd_idx][upd_way]   <= CNT_W'(1);
            end else if (cnt_q[upd_idx][upd_way] != CNT_MAX) begin
                cnt_q[upd_idx][upd_way]   <= cnt_q[upd_idx][upd_way] + 1'b1;
            end
        end
    end

    // Tag storage, written only when a line is installed.
    always_ff @(posedge clk) begin
        if (upd_en && upd_fill) begin
            tag_q[upd_idx][upd_way] <= upd_tag;
        end
    end

    // Which age ranks appear in the read set (assertion support).
    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            age_seen[rd_age[w]] = 1'b1;
        end
    end

    assert_age_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        age_seen == {WAYS{1'b1}});

    assert_cnt_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_fill && !flush && cnt_q[upd_idx][upd_way] == CNT_MAX)
        |=> cnt_q[$past(upd_idx)][$past(upd_way)] == CNT_MAX);

    assert_fill_count_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_fill && !flush)
        |=> cnt_q[$past(upd_idx)][$past(upd_way)] == CNT_W'(1));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0 && cnt_q == '0));

endmodule

// File: rtl/icache_victim.sv
// Combinational victim choice for one set.
// Invalid ways win first, lowest number first. Otherwise, in LRU mode the way
// of oldest age rank is chosen, and in LFU mode the smallest count, lowest way
// on ties. Assumes ages form a permutation of 0..WAYS-1.
module icache_victim #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        lfu,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][CNT_W-1:0]  cnt,
    input  logic [WAYS-1:0][WAY_W-1:0]  age,
    output logic [WAY_W-1:0]            victim
);
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] lfu_way;
    logic [WAY_W-1:0] lru_way;
    logic             any_inv;

    // Lowest-numbered invalid way.
    always_comb begin
        inv_way = '0;
        any_inv = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_way = WAY_W'(w);
                any_inv = 1'b1;
            end
        end
    end

    // Smallest count, keeping the earlier way on a tie.
    always_comb begin
        lfu_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (cnt[w] < cnt[lfu_way]) begin
                lfu_way = WAY_W'(w);
            end
        end
    end

    // Way holding the oldest age rank.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age[w] == WAY_W'(WAYS - 1)) begin
                lru_way = WAY_W'(w);
            end
        end
    end

    // Final pick by priority.
    always_comb begin
        if (any_inv)  victim = inv_way;
        else if (lfu) victim = lfu_way;
        else          victim = lru_way;
    end

endmodule

// File: rtl/icache_data.sv
// Line data registers: SETS x WAYS lines of WORDS 32-bit words.
// A whole line is written in one cycle at install. Reads are combinational.
// Contents are not reset: a line is only read after its valid bit is set.
module icache_data #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int WORDS = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [WORDS-1:0][31:0]       wr_line,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [WAY_W-1:0]             rd_way,
    input  logic [WSEL_W-1:0]            rd_word,
    output logic [31:0]                  rd_data
);
    logic [31:0] mem_q [SETS][WAYS][WORDS];

    // Install a full line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < WORDS; k++) begin
                mem_q[wr_idx][wr_way][k] <= wr_line[k];
            end
        end
    end

    // Word read.
    assign rd_data = mem_q[rd_idx][rd_way][rd_word];

endmodule

// File: rtl/icache_ro.sv
// Read-only set-associative instruction cache, top level.
// Accepts one fetch at a time. A hit responds the next cycle. A miss requests
// one line, collects it word by word, installs it and responds. Addresses
// outside [win_base, win_limit) go to the bypass port.
// Assumes cpu_req is held until cpu_ready, policy_lfu changes only when idle,
// and the window bounds are line aligned.
module icache_ro #(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int LINE_BYTES = 16,
    parameter int CNT_W      = 3,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WORDS  = LINE_BYTES / 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              policy_lfu,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              ref_req,
    output logic [ADDR_W-1:0] ref_addr,
    input  logic              ref_valid,
    input  logic [31:0]       ref_data,
    output logic              byp_req,
    output logic [ADDR_W-1:0] byp_addr,
    input  logic              byp_ack,
    input  logic [31:0]       byp_rdata
);
    import icache_pkg::*;

    ic_state_e               state_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [WAY_W-1:0]        vict_q;
    logic [WSEL_W-1:0]       fill_cnt_q;
    logic [WORDS-1:0][31:0]  line_q;
    logic [31:0]             rdata_q;

    logic [ADDR_W-1:0]       cur_addr;
    logic [IDX_W-1:0]        cur_idx;
    logic [TAG_W-1:0]        cur_tag;
    logic [WSEL_W-1:0]       cur_word;
    logic                    in_win;
    logic                    accept;

    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0][TAG_W-1:0]   set_tag;
    logic [WAYS-1:0][CNT_W-1:0]   set_cnt;
    logic [WAYS-1:0][WAY_W-1:0]   set_age;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [31:0]                  rd_data;

    logic                    upd_en;
    logic                    upd_fill;
    logic [WAY_W-1:0]        upd_way;

    // Address being worked on: live input while idle, latched otherwise.
    assign cur_addr = (state_q == ST_IDLE) ? cpu_addr : addr_q;
    assign cur_idx  = cur_addr[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_word = cur_addr[2 +: WSEL_W];
    assign in_win   = (cur_addr >= win_base) && (cur_addr < win_limit);
    assign accept   = (state_q == ST_IDLE) && cpu_req;

    // Per-way tag comparators.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tag[w] == cur_tag);
    end
    assign hit = |hit_vec;

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Replacement state update on a window hit or on install.
    assign upd_en   = (accept && in_win && hit) || (state_q == ST_COMMIT);
    assign upd_fill = (state_q == ST_COMMIT);
    assign upd_way  = upd_fill ? vict_q : hit_way;

    icache_tags #(
        .WAYS (WAYS),
        .SETS (SETS),
        .TAG_W(TAG_W),
        .CNT_W(CNT_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_idx  (cur_idx),
        .rd_valid(set_valid),
        .rd_tag  (set_tag),
        .rd_cnt  (set_cnt),
        .rd_age  (set_age),
        .upd_en  (upd_en),
        .upd_fill(upd_fill),
        .upd_idx (cur_idx),
        .upd_way (upd_way),
        .upd_tag (cur_tag)
    );

    icache_victim #(
        .WAYS (WAYS),
        .CNT_W(CNT_W)
    ) u_victim (
        .lfu   (policy_lfu),
        .valid (set_valid),
        .cnt   (set_cnt),
        .age   (set_age),
        .victim(victim)
    );

    icache_data #(
        .WAYS (WAYS),
        .SETS (SETS),
        .WORDS(WORDS)
    ) u_data (
        .clk    (clk),
        .wr_en  (state_q == ST_COMMIT),
        .wr_idx (cur_idx),
        .wr_way (vict_q),
        .wr_line(line_q),
        .rd_idx (cur_idx),
        .rd_way (hit_way),
        .rd_word(cur_word),
        .rd_data(rd_data)
    );

    // Control sequence and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            vict_q     <= '0;
            fill_cnt_q <= '0;
            rdata_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        addr_q <= cpu_addr;
                        if (!in_win) begin
                            state_q <= ST_BYP;
                        end else if (hit) begin
                            rdata_q <= rd_data;
                            state_q <= ST_DONE;
                        end else begin
                            vict_q  <= victim;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    fill_cnt_q <= '0;
                    state_q    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (ref_valid) begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (fill_cnt_q == WSEL_W'(WORDS - 1)) state_q <= ST_COMMIT;
                    end
                end
                ST_COMMIT: begin
                    rdata_q <= line_q[cur_word];
                    state_q <= ST_DONE;
                end
                ST_BYP: begin
                    if (byp_ack) begin
                        rdata_q <= byp_rdata;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Refill word collection buffer.
    always_ff @(posedge clk) begin
        if (state_q == ST_WAIT && ref_valid) begin
            line_q[fill_cnt_q] <= ref_data;
        end
    end

    assign cpu_ready = (state_q == ST_DONE);
    assign cpu_rdata = rdata_q;
    assign ref_req   = (state_q == ST_REQ);
    assign ref_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign byp_req   = (state_q == ST_BYP);
    assign byp_addr  = addr_q;

    // Helper for the LFU victim check: some way has a smaller count.
    logic smaller_exists;
    always_comb begin
        smaller_exists = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (set_cnt[w] < set_cnt[victim]) smaller_exists = 1'b1;
        end
    end

    assert_hit_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_win && hit) |=> (cpu_ready && !ref_req));

    assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_single_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !ref_req);

    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ref_addr[OFF_W-1:0] == '0));

    assert_bypass_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_win) |=> (byp_req && !ref_req));

    assert_invalid_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_win && !hit && !(&set_valid)) |-> !set_valid[victim]);

    assert_lru_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_win && !hit && (&set_valid) && !policy_lfu)
        |-> set_age[victim] == WAY_W'(WAYS - 1));

    assert_lfu_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_win && !hit && (&set_valid) && policy_lfu) |-> !smaller_exists);

    assert_policy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> $stable(policy_lfu));

endmodule

// File: tb/sim_icache_ro.sv
// Self-checking bench: full-geometry sweep plus directed replacement cases.
module sim_icache_ro;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        policy_lfu = 1'b0;
    logic [31:0] win_base = 32'h1000_0000;
    logic [31:0] win_limit = 32'h1000_4000;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        ref_req;
    logic [31:0] ref_addr;
    logic        ref_valid = 1'b0;
    logic [31:0] ref_data = '0;
    logic        byp_req;
    logic [31:0] byp_addr;
    logic        byp_ack = 1'b0;
    logic [31:0] byp_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int ref_cnt = 0;
    int byp_cnt = 0;
    logic [31:0] last_ref = '0;

    always #2.5 clk = ~clk;

    icache_ro u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .policy_lfu(policy_lfu),
        .win_base(win_base), .win_limit(win_limit),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .ref_req(ref_req), .ref_addr(ref_addr), .ref_valid(ref_valid), .ref_data(ref_data),
        .byp_req(byp_req), .byp_addr(byp_addr), .byp_ack(byp_ack), .byp_rdata(byp_rdata)
    );

    function automatic logic [31:0] flash_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] byp_word(input logic [31:0] a);
        return ~({a[31:2], 2'b00} ^ 32'h0F0F_F0F0);
    endfunction

    function automatic logic [31:0] la(input int t, input int s, input int w);
        return 32'h1000_0000 + 32'(t * 256 + s * 16 + w * 4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Flash model: slow start, then four words in ascending order.
    initial begin
        forever begin
            @(negedge clk);
            if (ref_req === 1'b1) begin
                logic [31:0] base;
                base = ref_addr;
                ref_cnt++;
                last_ref = ref_addr;
                repeat (2) @(negedge clk);
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    ref_valid = 1'b1;
                    ref_data  = flash_word(base + 32'(i * 4));
                end
                @(negedge clk);
                ref_valid = 1'b0;
            end
        end
    end

    // Bypass model: answers one cycle after seeing a request.
    initial begin
        forever begin
            @(negedge clk);
            if (byp_req === 1'b1 && !byp_ack) begin
                byp_cnt++;
                byp_ack   = 1'b1;
                byp_rdata = byp_word(byp_addr);
                @(negedge clk);
                byp_ack = 1'b0;
            end
        end
    end

    // One fetch with expected hit/miss; checks data, refill and bypass traffic.
    task automatic fetch(input logic [31:0] a, input bit exp_hit, input string req);
        int r0, b0, lat;
        bit inside_win;
        logic [31:0] exp;
        inside_win = (a >= win_base) && (a < win_limit);
        exp = inside_win ? flash_word(a) : byp_word(a);
        @(negedge clk);
        while (cpu_ready) @(negedge clk);
        r0 = ref_cnt;
        b0 = byp_cnt;
        cpu_req  = 1'b1;
        cpu_addr = a;
        lat = 0;
        do begin
            @(posedge clk);
            #1;
            lat++;
        end while (!cpu_ready && lat < 1000);
        cpu_req = 1'b0;
        check(cpu_rdata == exp, req, $sformatf("data @%h", a), cpu_rdata, exp);
        if (!inside_win) begin
            check(ref_cnt == r0 && byp_cnt == b0 + 1, req, $sformatf("bypass traffic @%h", a),
                  32'(ref_cnt - r0), 32'h0);
        end else if (exp_hit) begin
            check(ref_cnt == r0 && lat == 1, req, $sformatf("hit @%h refills/latency", a),
                  32'((ref_cnt - r0) * 256 + lat), 32'h1);
        end else begin
            check(ref_cnt == r0 + 1, req, $sformatf("miss @%h refill count", a),
                  32'(ref_cnt - r0), 32'h1);
            check(last_ref == {a[31:4], 4'h0}, req, "refill address", last_ref, {a[31:4], 4'h0});
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (cpu_ready) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic set_policy(input logic lfu);
        @(negedge clk);
        while (cpu_ready) @(negedge clk);
        policy_lfu = lfu;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(!cpu_ready && !ref_req && !byp_req, "R1", "reset outputs idle",
              {29'b0, cpu_ready, ref_req, byp_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 R2 R11: fill every slot, mixing the missed word position.
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++)
                fetch(la(t, s, (s + t) % 4), 1'b0, "R2");
        // R1 R10: every word of every line hits.
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++)
                for (int w = 0; w < 4; w++)
                    fetch(la(t, s, w), 1'b1, "R10");
        // R5: tag 0 is oldest in each set, so tag 4 evicts it.
        for (int s = 0; s < 16; s++) fetch(la(4, s, 1), 1'b0, "R5");
        for (int s = 0; s < 16; s++) fetch(la(0, s, 2), 1'b0, "R5");

        // R9: flush empties the cache.
        do_flush();
        fetch(la(4, 3, 0), 1'b0, "R9");
        fetch(la(2, 3, 0), 1'b0, "R9");

        // R4 R6: after flush, fills go to ways 0..3, tie evicts way 0.
        set_policy(1'b1);
        do_flush();
        for (int t = 0; t < 4; t++) fetch(la(t, 5, 0), 1'b0, "R4");
        fetch(la(4, 5, 0), 1'b0, "R4");
        fetch(la(1, 5, 0), 1'b1, "R4");
        fetch(la(2, 5, 0), 1'b1, "R4");
        fetch(la(3, 5, 0), 1'b1, "R4");
        fetch(la(0, 5, 0), 1'b0, "R4");

        // R6: counts t0=3 t1=2 t2=1 t3=3, so t2 is evicted.
        do_flush();
        for (int t = 0; t < 4; t++) fetch(la(t, 7, 0), 1'b0, "R6");
        fetch(la(0, 7, 1), 1'b1, "R6");
        fetch(la(0, 7, 2), 1'b1, "R6");
        fetch(la(1, 7, 1), 1'b1, "R6");
        fetch(la(3, 7, 1), 1'b1, "R6");
        fetch(la(3, 7, 2), 1'b1, "R6");
        fetch(la(4, 7, 0), 1'b0, "R6");
        fetch(la(2, 7, 0), 1'b0, "R6");
        fetch(la(0, 7, 3), 1'b1, "R6");
        fetch(la(1, 7, 3), 1'b1, "R6");
        fetch(la(3, 7, 3), 1'b1, "R6");
        fetch(la(4, 7, 3), 1'b0, "R6");

        // R7: t0 driven past saturation must stay the largest count.
        do_flush();
        for (int t = 0; t < 4; t++) fetch(la(t, 9, 0), 1'b0, "R7");
        for (int i = 0; i < 7; i++) fetch(la(0, 9, i % 4), 1'b1, "R7");
        fetch(la(1, 9, 1), 1'b1, "R7");
        fetch(la(1, 9, 2), 1'b1, "R7");
        fetch(la(2, 9, 1), 1'b1, "R7");
        fetch(la(4, 9, 0), 1'b0, "R7");
        fetch(la(0, 9, 3), 1'b1, "R7");
        fetch(la(3, 9, 0), 1'b0, "R7");

        // R5 R8: LRU order after mixed hits, then switching keeps lines.
        set_policy(1'b0);
        do_flush();
        for (int t = 0; t < 4; t++) fetch(la(t, 6, 0), 1'b0, "R5");
        fetch(la(0, 6, 1), 1'b1, "R5");
        fetch(la(4, 6, 0), 1'b0, "R5");
        fetch(la(0, 6, 2), 1'b1, "R5");
        fetch(la(2, 6, 2), 1'b1, "R5");
        fetch(la(3, 6, 2), 1'b1, "R5");
        fetch(la(1, 6, 0), 1'b0, "R5");
        fetch(la(4, 6, 1), 1'b0, "R5");
        for (int t = 0; t < 4; t++) fetch(la(t, 11, 0), 1'b0, "R8");
        set_policy(1'b1);
        for (int t = 0; t < 4; t++) fetch(la(t, 11, 3), 1'b1, "R8");
        set_policy(1'b0);
        for (int t = 0; t < 4; t++) fetch(la(t, 11, 2), 1'b1, "R8");

        // R3: window edges and no side effects on cached lines.
        fetch(32'h1000_3FFC, 1'b0, "R3");
        fetch(32'h1000_4000, 1'b0, "R3");
        fetch(32'h0FFF_FFFC, 1'b0, "R3");
        fetch(32'h1000_0000, 1'b0, "R3");
        fetch(32'h0000_2004, 1'b0, "R3");
        fetch(32'h1000_3FF0, 1'b1, "R3");
        fetch(32'h1000_0004, 1'b1, "R3");
        for (int t = 0; t < 4; t++) fetch(la(t, 11, 1), 1'b1, "R3");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule